// File: doc/BRIEF.md
# Sixteen-Bit Mode-Selectable Up-Counter

This block is a 16-bit up-counter. A 4-bit mode field sets how it counts. In free-running mode the count rolls over from all ones to zero. In the two clear-on-match modes the count returns to zero when it reaches a top value, taken from one of two registers:

- a compare register, or
- a capture register.

The counter advances only on cycles where a prescaled tick input is high. Software can load a new count at any time through a write port, and a load takes priority over counting.

A sticky overflow flag records each rollover from 0xFFFF to zero and acts as a seventeenth count bit. Only an explicit clear strobe lowers it, which stands in for an interrupt acknowledge. A single-cycle top-match pulse marks each counting tick that clears the counter on a match. The block is meant to sit behind a prescaler and a register file.

Top module: `seq_timer16`

## Requirements
- R1: After synchronous reset, the count is 0x0000, the overflow flag is 0 and the top-match output is 0.
- R2: When the write enable is high, the count equals the write data after the next clock edge. This holds whatever the tick, the mode or the current count.
- R3: When neither the write enable nor the tick is high, the count keeps its value across the clock edge.
- R4: Mode value 0 (free-running) increments the count by one on each tick and rolls from 0xFFFF to 0x0000. The count never clears when it equals the compare or capture register.
- R5: The overflow flag becomes 1 on the same clock edge on which a counting tick moves the count from 0xFFFF to 0x0000. This applies in every mode, including a match clear with a top of 0xFFFF. A match clear from a top below 0xFFFF does not set the flag.
- R6: The overflow flag stays 1 until a cycle in which the clear strobe is high. It reads 0 after that edge, unless a rollover happens in the same cycle, in which case the flag stays 1.
- R7: Mode value 4 takes the top from the compare register. A tick while the count equals that register returns the count to 0x0000 on the next edge.
- R8: Mode value 12 takes the top from the capture register, and the compare register has no effect on counting.
- R9: The top-match output is high only during a cycle in which all of the following hold: mode 4 or 12 is selected, the tick is high, the write enable is low, and the count equals the selected top. In every other cycle it is low.
- R10: Every mode value other than 0, 4 and 12 behaves exactly as mode 0.
- R11: In a clear-on-match mode, a count above the top keeps incrementing, rolls over at 0xFFFF and sets the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Prescaled count enable |
| mode | input | 4 | Counting mode select (0, 4, 12; others act as 0) |
| cmp_top | input | 16 | Compare register, top value in mode 4 |
| cap_top | input | 16 | Capture register, top value in mode 12 |
| wr_en | input | 1 | Count write strobe |
| wr_data | input | 16 | Value loaded into the count |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| count | output | 16 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| top_hit | output | 1 | Top-match pulse for the clearing tick |

## Verification
A wrong step choice inside the counter shows on `count` one clock edge after the offending tick. Examples are a missed clear, a clear in free-running mode, or the wrong top register. The error then persists in every later value, because the count is pure state. A flag fault shows on `ovf_flag` on the edge that rolls the count over, and it stays visible until the next clear strobe, because the flag is sticky. A faulty match decode shows at once on `top_hit` within the same cycle, and one edge later as a count that is not zero.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        MODE_FREE    = 4'd0,
        MODE_CLR_CMP = 4'd4,
        MODE_CLR_CAP = 4'd12
    } tmr_mode_e;

    typedef struct packed {
        logic clr_on_match;
        logic top_from_cap;
    } tmr_cfg_t;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_LOAD = 2'd1,
        STEP_INC  = 2'd2,
        STEP_ZERO = 2'd3
    } tmr_step_e;

    function automatic tmr_cfg_t decode_mode(input logic [MODE_W-1:0] m);
        tmr_cfg_t c;
        c.clr_on_match = 1'b0;
        c.top_from_cap = 1'b0;
        if (m == MODE_CLR_CMP) begin
            c.clr_on_match = 1'b1;
        end else if (m == MODE_CLR_CAP) begin
            c.clr_on_match = 1'b1;
            c.top_from_cap = 1'b1;
        end
        return c;
    endfunction

endpackage

// File: rtl/tmr16_mode_dec.sv
module tmr16_mode_dec
    import tmr16_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output tmr_cfg_t          cfg
);
    always_comb begin
        cfg = decode_mode(mode);
    end
endmodule

// File: rtl/tmr16_top_mux.sv
module tmr16_top_mux #(
    parameter int W = 16
) (
    input  logic         use_cap,
    input  logic [W-1:0] cmp_val,
    input  logic [W-1:0] cap_val,
    output logic [W-1:0] top_val
);
    always_comb begin
        top_val = use_cap ? cap_val : cmp_val;
    end
endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter
    import tmr16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         clr_mode,
    input  logic [W-1:0] top_val,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cnt_q,
    output logic         wrap_evt,
    output logic         match_evt
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    tmr_step_e    step;
    logic         at_top;
    logic         at_max;
    logic [W-1:0] cnt_d;

    always_comb begin
        at_top = (cnt_q == top_val);
        at_max = (cnt_q == CNT_MAX);
        if (wr_en) begin
            step = STEP_LOAD;
        end else if (!tick) begin
            step = STEP_HOLD;
        end else if (clr_mode && at_top) begin
            step = STEP_ZERO;
        end else begin
            step = STEP_INC;
        end
    end

    always_comb begin
        unique case (step)
            STEP_LOAD: cnt_d = wr_data;
            STEP_ZERO: cnt_d = '0;
            STEP_INC:  cnt_d = cnt_q + 1'b1;
            default:   cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        match_evt = (step == STEP_ZERO);
        wrap_evt  = ((step == STEP_INC) || (step == STEP_ZERO)) && at_max;
    end
endmodule

// File: rtl/tmr16_ovf_flag.sv
module tmr16_ovf_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_req,
    output logic flag_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (set_evt) begin
            flag_q <= 1'b1;
        end else if (clr_req) begin
            flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/seq_timer16.sv
module seq_timer16
    import tmr16_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [MODE_W-1:0] mode,
    input  logic [CW-1:0]     cmp_top,
    input  logic [CW-1:0]     cap_top,
    input  logic              wr_en,
    input  logic [CW-1:0]     wr_data,
    input  logic              ovf_clr,
    output logic [CW-1:0]     count,
    output logic              ovf_flag,
    output logic              top_hit
);
    tmr_cfg_t      cfg;
    logic [CW-1:0] top_val;
    logic          wrap_evt;
    logic          match_evt;

    tmr16_mode_dec u_dec (
        .mode (mode),
        .cfg  (cfg)
    );

    tmr16_top_mux #(.W(CW)) u_mux (
        .use_cap (cfg.top_from_cap),
        .cmp_val (cmp_top),
        .cap_val (cap_top),
        .top_val (top_val)
    );

    tmr16_counter #(.W(CW)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .clr_mode  (cfg.clr_on_match),
        .top_val   (top_val),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .cnt_q     (count),
        .wrap_evt  (wrap_evt),
        .match_evt (match_evt)
    );

    tmr16_ovf_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_evt (wrap_evt),
        .clr_req (ovf_clr),
        .flag_q  (ovf_flag)
    );

    assign top_hit = match_evt;
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         tick,
    input logic [3:0]   mode,
    input logic [W-1:0] cmp_top,
    input logic [W-1:0] cap_top,
    input logic         wr_en,
    input logic [W-1:0] wr_data,
    input logic         ovf_clr,
    input logic [W-1:0] count,
    input logic         ovf_flag,
    input logic         top_hit
);
    localparam logic [W-1:0] ALL1 = {W{1'b1}};

    logic is_clr_mode;
    logic [W-1:0] sel_top;
    logic rolls;
    always_comb begin
        is_clr_mode = (mode == 4'd4) || (mode == 4'd12);
        sel_top     = (mode == 4'd12) ? cap_top : cmp_top;
        rolls       = tick && !wr_en && (count == ALL1);
    end

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (count == '0) && !ovf_flag);

    p_write_load_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> count == $past(wr_data));

    p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !tick) |=> $stable(count));

    p_free_inc_r4: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && tick && !is_clr_mode) |=> count == $past(count) + 1'b1);

    p_ovf_set_r5: assert property (@(posedge clk) disable iff (rst)
        rolls |=> ovf_flag);

    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    p_ovf_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (ovf_clr && !rolls) |=> !ovf_flag);

    p_match_zero_r7: assert property (@(posedge clk) disable iff (rst)
        top_hit |=> count == '0);

    p_hit_cond_r9: assert property (@(posedge clk) disable iff (rst)
        top_hit |-> (is_clr_mode && tick && !wr_en && count == sel_top));

    p_hit_needed_r8: assert property (@(posedge clk) disable iff (rst)
        (is_clr_mode && tick && !wr_en && count == sel_top) |-> top_hit);
endmodule

bind seq_timer16 tmr16_chk #(.W(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .mode     (mode),
    .cmp_top  (cmp_top),
    .cap_top  (cap_top),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ovf_clr  (ovf_clr),
    .count    (count),
    .ovf_flag (ovf_flag),
    .top_hit  (top_hit)
);

// File: tb/tb_seq_timer16.sv
`timescale 1ns/1ps
module tb_seq_timer16;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick;
    logic [3:0]  mode;
    logic [15:0] cmp_top;
    logic [15:0] cap_top;
    logic        wr_en;
    logic [15:0] wr_data;
    logic        ovf_clr;
    logic [15:0] count;
    logic        ovf_flag;
    logic        top_hit;

    always #2.5 clk = ~clk;

    seq_timer16 dut (
        .clk(clk), .rst(rst), .tick(tick), .mode(mode),
        .cmp_top(cmp_top), .cap_top(cap_top),
        .wr_en(wr_en), .wr_data(wr_data), .ovf_clr(ovf_clr),
        .count(count), .ovf_flag(ovf_flag), .top_hit(top_hit)
    );

    typedef struct {
        logic [15:0] cnt;
        logic        flg;
        string       req;
    } exp_t;

    exp_t        sb[$];
    int          n_run  = 0;
    int          n_fail = 0;
    logic [15:0] m_cnt;
    logic        m_flg;
    bit          finished = 0;

    // monitor: compares each registered result right after the edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_run++;
            if (count !== e.cnt || ovf_flag !== e.flg) begin
                n_fail++;
                $display("FAIL %s: count=%h flag=%b expected count=%h flag=%b",
                         e.req, count, ovf_flag, e.cnt, e.flg);
            end
        end
    end

    // driver: applies one cycle of stimulus, checks top_hit, pushes the expected state
    task automatic step(input logic t, input logic w, input logic [15:0] d,
                        input logic c, input string req);
        logic clrm;
        logic [15:0] top;
        logic hit;
        logic rollover;
        exp_t e;
        @(negedge clk);
        tick = t; wr_en = w; wr_data = d; ovf_clr = c;
        #1;
        clrm = (mode == 4'd4) || (mode == 4'd12);
        top  = (mode == 4'd12) ? cap_top : cmp_top;
        hit  = clrm && t && !w && (m_cnt == top);
        n_run++;
        if (top_hit !== hit) begin
            n_fail++;
            $display("FAIL %s/R9: top_hit=%b expected %b", req, top_hit, hit);
        end
        rollover = t && !w && (m_cnt == 16'hFFFF);
        if (w)        m_cnt = d;
        else if (hit) m_cnt = 16'h0000;
        else if (t)   m_cnt = m_cnt + 16'd1;
        if (rollover)  m_flg = 1'b1;
        else if (c)    m_flg = 1'b0;
        e.cnt = m_cnt; e.flg = m_flg; e.req = req;
        sb.push_back(e);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tick = 0; mode = 4'd0; cmp_top = 16'h0; cap_top = 16'h0;
        wr_en = 0; wr_data = 16'h0; ovf_clr = 0;
        m_cnt = 16'h0; m_flg = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        n_run++;
        if (count !== 16'h0 || ovf_flag !== 1'b0 || top_hit !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: count=%h flag=%b hit=%b expected 0000 0 0",
                     count, ovf_flag, top_hit);
        end

        // free-running mode: load near max, compare value must not clear (R2, R4)
        mode = 4'd0; cmp_top = 16'hFFFD; cap_top = 16'hFFFE;
        step(0, 1, 16'hFFFC, 0, "R2");
        step(1, 0, 16'h0, 0, "R4");
        step(1, 0, 16'h0, 0, "R4");
        step(1, 0, 16'h0, 0, "R4");
        step(1, 0, 16'h0, 0, "R5");          // FFFF -> 0000, flag set
        step(0, 0, 16'h0, 0, "R3");          // no tick: hold
        step(0, 0, 16'h0, 0, "R3");
        step(1, 0, 16'h0, 0, "R6");          // flag sticky while counting
        step(0, 0, 16'h0, 1, "R6");          // clear strobe
        step(1, 1, 16'h1234, 0, "R2");       // write beats tick
        step(0, 1, 16'hFFFF, 0, "R2");
        step(1, 0, 16'h0, 1, "R6");          // rollover and clear together: flag stays
        step(0, 0, 16'h0, 1, "R6");

        // mode 4: compare register is top, capture ignored (R7, R9)
        mode = 4'd4; cmp_top = 16'd5; cap_top = 16'd2;
        step(0, 1, 16'd0, 0, "R2");
        for (int i = 0; i < 5; i++) step(1, 0, 16'h0, 0, "R7");
        step(0, 0, 16'h0, 0, "R9");          // at top without tick: no hit, hold
        step(1, 0, 16'h0, 0, "R7");          // clears, no overflow (R5)
        step(1, 0, 16'h0, 0, "R7");
        step(0, 1, 16'd5, 0, "R9");
        step(1, 1, 16'd9, 0, "R9");          // write at top suppresses hit

        // mode 12: capture register is top, compare ignored (R8)
        mode = 4'd12; cmp_top = 16'd1; cap_top = 16'd3;
        step(0, 1, 16'd0, 0, "R8");
        for (int i = 0; i < 5; i++) step(1, 0, 16'h0, 0, "R8");

        // count above top rolls over and sets flag (R11)
        mode = 4'd4; cmp_top = 16'd10;
        step(0, 1, 16'hFFFE, 1, "R11");
        step(1, 0, 16'h0, 0, "R11");
        step(1, 0, 16'h0, 0, "R11");
        step(1, 0, 16'h0, 0, "R11");
        step(0, 0, 16'h0, 1, "R6");

        // match clear from top 0xFFFF sets flag (R5)
        cmp_top = 16'hFFFF;
        step(0, 1, 16'hFFFE, 0, "R5");
        step(1, 0, 16'h0, 0, "R5");
        step(1, 0, 16'h0, 0, "R5");
        step(0, 0, 16'h0, 1, "R6");

        // undefined modes behave as free-running (R10)
        mode = 4'd7; cmp_top = 16'd3; cap_top = 16'd3;
        step(0, 1, 16'd2, 0, "R10");
        for (int i = 0; i < 3; i++) step(1, 0, 16'h0, 0, "R10");
        mode = 4'd15;
        step(0, 1, 16'hFFFE, 0, "R10");
        for (int i = 0; i < 3; i++) step(1, 0, 16'h0, 0, "R10");

        step(0, 0, 16'h0, 0, "R3");
        repeat (3) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule